// File: doc/BRIEF.md
# UART Interrupt Identification Arbiter

This block is the interrupt front end of a 16550-style serial port. It holds the interrupt-enable register, answers reads of the interrupt-identification register, and drives the port's single interrupt line. The surrounding receive, line-status and modem logic hands it four live conditions: an overrun flag, the receive FIFO occupancy, the FIFO-mode enable bit and a modem-delta-pending flag. The block itself owns one piece of state besides the enable register: a transmit-holding-empty pending flag that is raised by events on the register bus and lowered by the identification read that reports it.

On every cycle the arbiter picks the highest-priority enabled source that is pending and turns it into a reason code. A read of the identification register returns that code, with the two FIFO-mode bits on top when FIFO mode is on. The interrupt line is a registered copy of "some enabled source is pending", so it follows every register access and every change of the input conditions one clock later.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After synchronous reset the enable register reads 0x00, the transmit-empty pending flag is clear, irq_o is 0 and bus_rdata is 0x00.
- R2: A write to the enable register (address 1) stores only bits [3:0]; a read of address 1 returns them with bits [7:4] zero. Bit 0 enables receive data, bit 1 transmit empty, bit 2 line status, bit 3 modem status.
- R3: The reported reason follows a fixed priority: line status (overrun flag with bit 2 enabled) over receive data (FIFO count nonzero with bit 0 enabled) over transmit empty (pending flag with bit 1 enabled) over modem status (delta pending with bit 3 enabled).
- R4: Reason codes in bits [3:0] of the identification value: 0x6 line status, 0xC receive data (the character-timeout code), 0x2 transmit empty, 0x0 modem status, 0x1 nothing pending; bits [5:4] are zero.
- R5: Every write to the data register (address 0) sets the transmit-empty pending flag.
- R6: A write to the enable register that changes bit 1 from 0 to 1 sets the pending flag; a write that leaves bit 1 at 1, or clears it, does not set it.
- R7: A read of the identification register (address 2) that reports transmit empty clears the pending flag, and returns the value from before the clear; a read that reports any other reason leaves the flag unchanged.
- R8: Bits [7:6] of the identification value are 2'b11 when fifo_en is 1 and 2'b00 otherwise.
- R9: irq_o is 1 in the cycle after any enabled source is pending and 0 in the cycle after none is.
- R10: Read data appears on bus_rdata one cycle after bus_rd; reads of any address other than 1 and 2 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ovr_flag | input | 1 | Receiver overrun condition |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| fifo_en | input | 1 | FIFO mode enable |
| msr_delta | input | 1 | Some modem status delta is pending |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach is a transmit-empty flag that survives an identification read because a higher-priority source masks it, followed by its release once that source drops; that needs the pending flag, the enable bits and the live conditions lined up in one order. Directed sequences build this case explicitly, including the repeat write that leaves the transmit enable at 1, and a long seeded random run of mixed writes, reads and input changes keeps checking every read and the interrupt line against a bench model of the flag.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    RSN_MODEM = 4'h0,
    RSN_NONE  = 4'h1,
    RSN_TXE   = 4'h2,
    RSN_LINE  = 4'h6,
    RSN_RXTO  = 4'hC
  } reason_e;

  // enable-register bit positions
  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;
  localparam int EN_W  = 4;

  // source slots in priority order, slot 0 highest
  localparam int NSRC = 4;

  // register offsets
  localparam int OFS_DATA = 0;
  localparam int OFS_IER  = 1;
  localparam int OFS_IIR  = 2;

  function automatic reason_e slot_code(input int slot);
    case (slot)
      0:       return RSN_LINE;
      1:       return RSN_RXTO;
      2:       return RSN_TXE;
      default: return RSN_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ier_wr,
  input  logic [EN_W-1:0] ier_wdata,
  input  logic            data_wr,
  input  logic            thre_clr,
  output logic [EN_W-1:0] ier_q,
  output logic            thre_q
);
  logic tx_rise;
  assign tx_rise = ier_wr && !ier_q[EN_TX] && ier_wdata[EN_TX];

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q  <= '0;
      thre_q <= 1'b0;
    end else begin
      if (ier_wr) ier_q <= ier_wdata;
      // a setting event in the same cycle wins over the clear
      if (data_wr || tx_rise) thre_q <= 1'b1;
      else if (thre_clr)      thre_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] src_pend,
  output reason_e         reason,
  output logic            any_pend
);
  always_comb begin
    reason = RSN_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (src_pend[i]) reason = slot_code(i);
    end
  end
  assign any_pend = |src_pend;
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ovr_flag,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              fifo_en,
  input  logic              msr_delta,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_IER  = ADDR_W'(OFS_IER);
  localparam logic [ADDR_W-1:0] A_IIR  = ADDR_W'(OFS_IIR);

  logic [EN_W-1:0] ier_q;
  logic            thre_pend;
  logic [NSRC-1:0] src_pend;
  reason_e         reason;
  logic            any_pend;
  logic            rd_iir;
  logic [7:0]      iir_val;

  assign rd_iir = bus_rd && (bus_addr == A_IIR);

  uart_irq_regs regs_i (
    .clk       (clk),
    .rst       (rst),
    .ier_wr    (bus_wr && (bus_addr == A_IER)),
    .ier_wdata (bus_wdata[EN_W-1:0]),
    .data_wr   (bus_wr && (bus_addr == A_DATA)),
    .thre_clr  (rd_iir && (reason == RSN_TXE)),
    .ier_q     (ier_q),
    .thre_q    (thre_pend)
  );

  assign src_pend[0] = ovr_flag  && ier_q[EN_LS];
  assign src_pend[1] = (rx_count != '0) && ier_q[EN_RX];
  assign src_pend[2] = thre_pend && ier_q[EN_TX];
  assign src_pend[3] = msr_delta && ier_q[EN_MS];

  uart_irq_prio prio_i (
    .src_pend (src_pend),
    .reason   (reason),
    .any_pend (any_pend)
  );

  assign iir_val = {{2{fifo_en}}, 2'b00, reason};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= any_pend;
      if (bus_rd) begin
        if (bus_addr == A_IER)      bus_rdata <= {{(8-EN_W){1'b0}}, ier_q};
        else if (bus_addr == A_IIR) bus_rdata <= iir_val;
        else                        bus_rdata <= 8'h00;
      end
    end
  end
endmodule

// File: rtl/uart_irq_arbiter_chk.sv
module uart_irq_arbiter_chk #(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              ovr_flag,
  input logic [CNT_W-1:0]  rx_count,
  input logic              fifo_en,
  input logic              msr_delta,
  input logic              irq_o,
  input logic [3:0]        ier_q,
  input logic              thre_pend
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  logic wr_data, rd_ier, rd_iir, hi_masks_tx, any_en;
  assign wr_data     = bus_wr && bus_addr == ADDR_W'(0);
  assign rd_ier      = bus_rd && bus_addr == ADDR_W'(1);
  assign rd_iir      = bus_rd && bus_addr == ADDR_W'(2);
  assign hi_masks_tx = (ovr_flag && ier_q[2]) || ((rx_count != '0) && ier_q[0]);
  assign any_en      = (ovr_flag && ier_q[2]) || ((rx_count != '0) && ier_q[0])
                     || (thre_pend && ier_q[1]) || (msr_delta && ier_q[3]);

  p_data_sets_pend_r5: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> thre_pend);

  p_tx_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_iir && thre_pend && ier_q[1] && !hi_masks_tx && !bus_wr) |=> !thre_pend);

  p_other_read_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_iir && thre_pend && hi_masks_tx) |=> thre_pend);

  p_ier_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(rd_ier)) |-> bus_rdata[7:4] == 4'h0);

  p_fifo_bits_r8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(rd_iir)) |-> bus_rdata[7:6] == {2{$past(fifo_en)}});

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> irq_o == $past(any_en));
endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .ovr_flag  (ovr_flag),
  .rx_count  (rx_count),
  .fifo_en   (fifo_en),
  .msr_delta (msr_delta),
  .irq_o     (irq_o),
  .ier_q     (ier_q),
  .thre_pend (thre_pend)
);

// File: tb/uart_irq_arbiter_tb.sv
module uart_irq_arbiter_tb_top;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata;
  logic              ovr_flag = 1'b0, fifo_en = 1'b0, msr_delta = 1'b0;
  logic [CNT_W-1:0]  rx_count = '0;
  logic              irq_o;

  always #5 clk = ~clk;

  uart_irq_arbiter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovr_flag(ovr_flag),
    .rx_count(rx_count), .fifo_en(fifo_en), .msr_delta(msr_delta), .irq_o(irq_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [3:0] m_ier = 4'h0;
  logic       m_thre = 1'b0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_code();
    if (ovr_flag && m_ier[2])               return 4'h6;
    if (rx_count != 0 && m_ier[0])          return 4'hC;
    if (m_thre && m_ier[1])                 return 4'h2;
    if (msr_delta && m_ier[3])              return 4'h0;
    return 4'h1;
  endfunction

  function automatic logic [7:0] exp_iir();
    return {{2{fifo_en}}, 2'b00, exp_code()};
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    if (a == 0) m_thre = 1;
    if (a == 1) begin
      if (!m_ier[1] && d[1]) m_thre = 1;
      m_ier = d[3:0];
    end
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    logic [7:0] e;
    e = (a == 1) ? {4'h0, m_ier} : (a == 2) ? exp_iir() : 8'h00;
    @(negedge clk);
    bus_rd = 1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
    if (a == 2 && e[3:0] == 4'h2) m_thre = 0;
    check((a == 2) ? "R4/R7/R8 iir" : "R2/R10 read", v, e);
  endtask

  task automatic chk_irq(input string req);
    logic e;
    e = (exp_code() != 4'h1);
    @(negedge clk);
    check(req, {7'h0, irq_o}, {7'h0, e});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 irq", {7'h0, irq_o}, 8'h00);
    rd(1, v);
    rd(2, v);              // R1: pending clear -> 0x01
    // R2 upper bits dropped
    wr(1, 8'hF0); rd(1, v);
    wr(1, 8'h00);
    // R5 data write then enable -> R6 rising edge too
    wr(0, 8'h41); wr(1, 8'h02); chk_irq("R9 irq tx");
    rd(2, v); check("R7 pre-clear value", v, 8'h02);
    rd(2, v); check("R7 cleared", v, 8'h01);
    chk_irq("R9 irq drop");
    // R6 staying at 1 does not set
    wr(1, 8'h02); rd(2, v); check("R6 no re-set", v, 8'h01);
    // R6 clearing then raising sets
    wr(1, 8'h00); wr(1, 8'h02); rd(2, v); check("R6 rise sets", v, 8'h02);
    // R3 priority cascade with all sources live
    wr(0, 8'h00); wr(1, 8'h0F);
    @(negedge clk); ovr_flag = 1; rx_count = 5'd3; msr_delta = 1; fifo_en = 1;
    rd(2, v); check("R3 line first", v, 8'hC6);
    rd(2, v); check("R7 kept under mask", v, 8'hC6);
    @(negedge clk); ovr_flag = 0;
    rd(2, v); check("R4 rx timeout code", v, 8'hCC);
    @(negedge clk); rx_count = 0;
    rd(2, v); check("R3 tx third", v, 8'h C2);
    rd(2, v); check("R3 modem last", v, 8'hC0);
    @(negedge clk); msr_delta = 0; fifo_en = 0;
    chk_irq("R9 idle");
    rd(5, v); // R10 other address
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: wr(0, 8'($urandom));
        1: wr(1, 8'($urandom));
        2: rd(2, v);
        3: rd($urandom_range(0, 7), v);
        default: begin
          @(negedge clk);
          ovr_flag  = ($urandom_range(0, 3) == 0);
          rx_count  = ($urandom_range(0, 2) == 0) ? CNT_W'($urandom_range(1, 16)) : '0;
          msr_delta = $urandom_range(0, 1);
          fifo_en   = $urandom_range(0, 1);
        end
      endcase
      @(negedge clk);
      chk_irq("R9 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule